// File: doc/BRIEF.md
# Debug Trigger Register File

This block keeps the three data words and the capability word of one hardware debug trigger. The words are the control word, the compare value, an auxiliary word and the info word. A CSR-style port carries a debug-mode flag, and it is the only way an ordinary instruction can change the registers. A second, privileged poke port can set bits that the CSR port may not touch. Each register has its own write mask and its own poke mask. A new value is merged with the old one through that mask, so bits outside the mask keep their old value.

The block does not store written values as they arrive. It makes them legal first. A control write with the type code 0 is stored as disabled. The action field is cleared unless the trigger is owned by debug mode. The ownership bit can only be changed from debug mode. An all-ones compare value written to a trigger in the newer match format is replaced by the largest allowed NAPOT mask. The block also records which registers the current instruction has modified. Until the instruction ends, a control-word read returns the value held before its first modification. The matching, chaining and counting units use the decoded fields that the block drives out: type, ownership, action, enable, chain and timing.

Top module: `dtrig_unit`

## Requirements
- R1: After reset the registers hold their parameter reset values (defaults: control 0xF000_0000, compare 0, auxiliary 0, info 0x0100_007C), no modified flag is set, and the decoded type is 15.
- R2: A CSR write to the control word (select 0) whose type field (bits 31:28) is 0 is stored with type 15, and the decoded enable is then 0.
- R3: After a CSR control write, if the stored type is 2 or 6 (address/data match) and the ownership bit (bit 27) is clear, action bits 15:12 become 0. If the stored type is 3 (instruction count) and the ownership bit is clear, action bits 5:0 become 0. If the ownership bit is set, the action is kept.
- R4: While the ownership bit is set, a CSR write to any register (select 0 control, 1 compare, 2 auxiliary, 3 info) without the debug-mode flag is refused. The write-accepted output is then low, no register changes and no modified flag is set.
- R5: A CSR control write made without the debug-mode flag cannot change the ownership bit.
- R6: A poke merges through the poke mask without legalising the type. If the result has the ownership bit clear and action bits 15:12 equal to 1, those bits are cleared.
- R7: Every write keeps the old value outside its mask. With the default masks, the auxiliary CSR mask is 0x0000_FFFF, the info CSR mask is 0 and all poke masks are all ones.
- R8: If the control type is 6, a compare value that becomes all ones after merging is stored as the NAPOT mask parameter (default 0xBFFF_FFFF). Under any other type, all ones is stored as written.
- R9: A CSR control write that leaves type 2 sets bits 26:21 to the NAPOT mask's trailing-zero count plus one (1 by default). A poke does not set these bits.
- R10: Each accepted CSR write sets the modified flag of its register (flag bit index = select). An instruction-end pulse clears the flags, unless a write lands in the same cycle. A control read returns the value held before the first write since the last instruction end, and returns the live value once the flag is clear.
- R11: When a CSR write is accepted for a register, a poke to the same register in the same cycle is dropped. A poke to a different register in the same cycle still takes effect.
- R12: The decoded fields follow the live control word. For types 2 and 6, chain is bit 11, and the enable is the OR of bits 6, 4 and 3 (type 6 also ORs in bits 24 and 23). Timing is bit 18 for type 2, 0 for type 6 and 1 for type 3. For type 3 the enable is the OR of bits 9, 7 and 6. Every other type decodes as not enabled, with action 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | CSR write request |
| csrSel | input | 2 | CSR target: 0 control, 1 compare, 2 auxiliary, 3 info |
| csrDbgMode | input | 1 | Write issued from debug mode |
| csrWrData | input | XLEN | CSR write value |
| csrWrOk | output | 1 | CSR write accepted this cycle |
| pokeEn | input | 1 | Privileged poke request |
| pokeSel | input | 2 | Poke target, same encoding as csrSel |
| pokeData | input | XLEN | Poke value |
| instEnd | input | 1 | End-of-instruction pulse |
| ctrlRd | output | XLEN | Control word as read by software |
| cmpRd | output | XLEN | Compare value |
| auxRd | output | XLEN | Auxiliary word |
| infoRd | output | XLEN | Info word |
| modFlags | output | 4 | Modified-by-this-instruction flags, index = select |
| trigType | output | 4 | Decoded type |
| dbgOwned | output | 1 | Ownership bit |
| trigAction | output | 6 | Decoded action |
| trigEnabled | output | 1 | Any privilege enable set |
| trigChain | output | 1 | Chain bit |
| trigTiming | output | 1 | 1 = fires after the instruction |

## Verification
The assertions check rules that hold in every cycle. A non-debug write never alters ownership. A refused compare write leaves the compare value stable. A type-0 control write always lands as 15. An unowned address/data trigger never holds the enter-debug action. Accepted writes raise their modified flag, and a bare instruction end clears all flags. The directed scenarios are the only place where exact stored values are shown: the mask merges, NAPOT substitution under type 6 but not type 2, the trailing-zero field, the poke rules, same-cycle priority, and the read of the pre-instruction value while the flag is set.

// File: rtl/dtrig_pkg.sv
package dtrig_pkg;

  localparam logic [3:0] TYPE_NONE  = 4'd0;
  localparam logic [3:0] TYPE_ADDR  = 4'd2;
  localparam logic [3:0] TYPE_ICNT  = 4'd3;
  localparam logic [3:0] TYPE_ADDR6 = 4'd6;
  localparam logic [3:0] TYPE_OFF   = 4'd15;

  localparam int NUM_REGS = 4;
  localparam int SEL_CTRL = 0;
  localparam int SEL_CMP  = 1;
  localparam int SEL_AUX  = 2;
  localparam int SEL_INFO = 3;

  // Strobes from the control unit to the register datapath.
  typedef struct packed {
    logic [NUM_REGS-1:0] csrWr;
    logic [NUM_REGS-1:0] poke;
    logic                dbg;
    logic                clrMod;
  } dtrig_strobe_t;

  function automatic int unsigned lowZeros(input logic [63:0] v, input int unsigned w);
    int unsigned n;
    n = w;
    for (int i = int'(w) - 1; i >= 0; i--) begin
      if (v[i]) n = int'(i);
    end
    return n;
  endfunction

endpackage

// File: rtl/dtrig_ctrl.sv
module dtrig_ctrl
  import dtrig_pkg::*;
(
  input  logic          csrWrEn,
  input  logic [1:0]    csrSel,
  input  logic          csrDbgMode,
  input  logic          pokeEn,
  input  logic [1:0]    pokeSel,
  input  logic          instEnd,
  input  logic          dbgOwned,
  output logic          csrWrOk,
  output dtrig_strobe_t stb
);

  logic accept;

  assign accept  = csrWrEn && (!dbgOwned || csrDbgMode);
  assign csrWrOk = accept;

  always_comb begin
    stb        = '0;
    stb.dbg    = csrDbgMode;
    stb.clrMod = instEnd;
    for (int i = 0; i < NUM_REGS; i++) begin
      stb.csrWr[i] = accept && (csrSel == 2'(i));
      stb.poke[i]  = pokeEn && (pokeSel == 2'(i)) && !stb.csrWr[i];
    end
  end

endmodule

// File: rtl/dtrig_regs.sv
module dtrig_regs
  import dtrig_pkg::*;
#(
  parameter int               XLEN       = 32,
  parameter logic [XLEN-1:0]  RST_CTRL   = 32'hF000_0000,
  parameter logic [XLEN-1:0]  RST_CMP    = '0,
  parameter logic [XLEN-1:0]  RST_AUX    = '0,
  parameter logic [XLEN-1:0]  RST_INFO   = 32'h0100_007C,
  parameter logic [XLEN-1:0]  WMASK_CTRL = '1,
  parameter logic [XLEN-1:0]  WMASK_CMP  = '1,
  parameter logic [XLEN-1:0]  WMASK_AUX  = 32'h0000_FFFF,
  parameter logic [XLEN-1:0]  WMASK_INFO = '0,
  parameter logic [XLEN-1:0]  PMASK_CTRL = '1,
  parameter logic [XLEN-1:0]  PMASK_CMP  = '1,
  parameter logic [XLEN-1:0]  PMASK_AUX  = '1,
  parameter logic [XLEN-1:0]  PMASK_INFO = '1,
  parameter logic [XLEN-1:0]  NAPOT_MASK = 32'hBFFF_FFFF
)(
  input  logic                clk,
  input  logic                rstN,
  input  dtrig_strobe_t       stb,
  input  logic [XLEN-1:0]     csrWrData,
  input  logic [XLEN-1:0]     pokeData,
  output logic [XLEN-1:0]     ctrlNow,
  output logic [XLEN-1:0]     ctrlRd,
  output logic [XLEN-1:0]     cmpRd,
  output logic [XLEN-1:0]     auxRd,
  output logic [XLEN-1:0]     infoRd,
  output logic [NUM_REGS-1:0] modFlags
);

  localparam int TYPE_LSB  = XLEN - 4;
  localparam int OWN_BIT   = XLEN - 5;
  localparam int MMAX_LSB  = XLEN - 11;
  localparam logic [5:0] MASKMAX = 6'(lowZeros(64'(NAPOT_MASK), XLEN) + 1);

  localparam logic [NUM_REGS*XLEN-1:0] WMASKS = {WMASK_INFO, WMASK_AUX, WMASK_CMP, WMASK_CTRL};
  localparam logic [NUM_REGS*XLEN-1:0] PMASKS = {PMASK_INFO, PMASK_AUX, PMASK_CMP, PMASK_CTRL};
  localparam logic [NUM_REGS*XLEN-1:0] RSTS   = {RST_INFO, RST_AUX, RST_CMP, RST_CTRL};

  logic [XLEN-1:0] ctrlQ, cmpQ, auxQ, infoQ, prevQ;
  logic [XLEN-1:0] csrVal, csrMask, ctrlCsrNext, ctrlPokeNext;
  logic [XLEN-1:0] cmpCsrNext, cmpPokeNext;
  logic [NUM_REGS-1:0] modQ;
  logic [3:0] curType;

  assign curType = ctrlQ[TYPE_LSB +: 4];

  // Control word: CSR path legalises type, ownership bit and action.
  always_comb begin
    csrVal = csrWrData;
    if (csrVal[TYPE_LSB +: 4] == TYPE_NONE) csrVal[TYPE_LSB +: 4] = TYPE_OFF;
    csrMask = WMASK_CTRL;
    if (!stb.dbg) csrMask[OWN_BIT] = 1'b0;
    ctrlCsrNext = (csrVal & csrMask) | (ctrlQ & ~csrMask);
    if (ctrlCsrNext[TYPE_LSB +: 4] == TYPE_ADDR || ctrlCsrNext[TYPE_LSB +: 4] == TYPE_ADDR6) begin
      if (!ctrlCsrNext[OWN_BIT]) ctrlCsrNext[15:12] = 4'd0;
      if (ctrlCsrNext[TYPE_LSB +: 4] == TYPE_ADDR) ctrlCsrNext[MMAX_LSB +: 6] = MASKMAX;
    end else if (ctrlCsrNext[TYPE_LSB +: 4] == TYPE_ICNT) begin
      if (!ctrlCsrNext[OWN_BIT]) ctrlCsrNext[5:0] = 6'd0;
    end
  end

  always_comb begin
    ctrlPokeNext = (pokeData & PMASK_CTRL) | (ctrlQ & ~PMASK_CTRL);
    if (!ctrlPokeNext[OWN_BIT] && ctrlPokeNext[15:12] == 4'd1) ctrlPokeNext[15:12] = 4'd0;
  end

  // Compare value: all ones under the newer format becomes the NAPOT limit.
  always_comb begin
    cmpCsrNext  = (csrWrData & WMASK_CMP) | (cmpQ & ~WMASK_CMP);
    cmpPokeNext = (pokeData & PMASK_CMP) | (cmpQ & ~PMASK_CMP);
    if (curType == TYPE_ADDR6 && cmpCsrNext == '1)  cmpCsrNext  = NAPOT_MASK;
    if (curType == TYPE_ADDR6 && cmpPokeNext == '1) cmpPokeNext = NAPOT_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= RST_CTRL;
      cmpQ  <= RST_CMP;
      auxQ  <= RST_AUX;
      infoQ <= RST_INFO;
      prevQ <= RST_CTRL;
    end else begin
      if (stb.csrWr[SEL_CTRL])     ctrlQ <= ctrlCsrNext;
      else if (stb.poke[SEL_CTRL]) ctrlQ <= ctrlPokeNext;
      if (stb.csrWr[SEL_CTRL] && (!modQ[SEL_CTRL] || stb.clrMod)) prevQ <= ctrlQ;
      if (stb.csrWr[SEL_CMP])      cmpQ <= cmpCsrNext;
      else if (stb.poke[SEL_CMP])  cmpQ <= cmpPokeNext;
      if (stb.csrWr[SEL_AUX])
        auxQ <= (csrWrData & WMASKS[SEL_AUX*XLEN +: XLEN]) | (auxQ & ~WMASKS[SEL_AUX*XLEN +: XLEN]);
      else if (stb.poke[SEL_AUX])
        auxQ <= (pokeData & PMASKS[SEL_AUX*XLEN +: XLEN]) | (auxQ & ~PMASKS[SEL_AUX*XLEN +: XLEN]);
      if (stb.csrWr[SEL_INFO])
        infoQ <= (csrWrData & WMASKS[SEL_INFO*XLEN +: XLEN]) | (infoQ & ~WMASKS[SEL_INFO*XLEN +: XLEN]);
      else if (stb.poke[SEL_INFO])
        infoQ <= (pokeData & PMASKS[SEL_INFO*XLEN +: XLEN]) | (infoQ & ~PMASKS[SEL_INFO*XLEN +: XLEN]);
    end
  end

  // One modified flag per register.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_mod
    always_ff @(posedge clk) begin
      if (!rstN)               modQ[g] <= 1'b0;
      else if (stb.csrWr[g])   modQ[g] <= 1'b1;
      else if (stb.clrMod)     modQ[g] <= 1'b0;
    end
  end

  logic unusedRst;
  assign unusedRst = ^RSTS;

  assign ctrlNow  = ctrlQ;
  assign ctrlRd   = modQ[SEL_CTRL] ? prevQ : ctrlQ;
  assign cmpRd    = cmpQ;
  assign auxRd    = auxQ;
  assign infoRd   = infoQ;
  assign modFlags = modQ;

endmodule

// File: rtl/dtrig_decode.sv
module dtrig_decode
  import dtrig_pkg::*;
#(
  parameter int XLEN = 32
)(
  input  logic [XLEN-1:0] ctrlNow,
  output logic [3:0]      trigType,
  output logic            dbgOwned,
  output logic [5:0]      trigAction,
  output logic            trigEnabled,
  output logic            trigChain,
  output logic            trigTiming
);

  assign trigType = ctrlNow[XLEN-4 +: 4];
  assign dbgOwned = ctrlNow[XLEN-5];

  always_comb begin
    trigAction  = 6'd0;
    trigEnabled = 1'b0;
    trigChain   = 1'b0;
    trigTiming  = 1'b0;
    unique case (trigType)
      TYPE_ADDR: begin
        trigAction  = {2'b00, ctrlNow[15:12]};
        trigEnabled = ctrlNow[6] | ctrlNow[4] | ctrlNow[3];
        trigChain   = ctrlNow[11];
        trigTiming  = ctrlNow[18];
      end
      TYPE_ADDR6: begin
        trigAction  = {2'b00, ctrlNow[15:12]};
        trigEnabled = ctrlNow[6] | ctrlNow[4] | ctrlNow[3] | ctrlNow[24] | ctrlNow[23];
        trigChain   = ctrlNow[11];
      end
      TYPE_ICNT: begin
        trigAction  = ctrlNow[5:0];
        trigEnabled = ctrlNow[9] | ctrlNow[7] | ctrlNow[6];
        trigTiming  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dtrig_unit.sv
module dtrig_unit
  import dtrig_pkg::*;
#(
  parameter int               XLEN       = 32,
  parameter logic [XLEN-1:0]  RST_CTRL   = 32'hF000_0000,
  parameter logic [XLEN-1:0]  RST_CMP    = '0,
  parameter logic [XLEN-1:0]  RST_AUX    = '0,
  parameter logic [XLEN-1:0]  RST_INFO   = 32'h0100_007C,
  parameter logic [XLEN-1:0]  WMASK_CTRL = '1,
  parameter logic [XLEN-1:0]  WMASK_CMP  = '1,
  parameter logic [XLEN-1:0]  WMASK_AUX  = 32'h0000_FFFF,
  parameter logic [XLEN-1:0]  WMASK_INFO = '0,
  parameter logic [XLEN-1:0]  PMASK_CTRL = '1,
  parameter logic [XLEN-1:0]  PMASK_CMP  = '1,
  parameter logic [XLEN-1:0]  PMASK_AUX  = '1,
  parameter logic [XLEN-1:0]  PMASK_INFO = '1,
  parameter logic [XLEN-1:0]  NAPOT_MASK = 32'hBFFF_FFFF
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrWrEn,
  input  logic [1:0]      csrSel,
  input  logic            csrDbgMode,
  input  logic [XLEN-1:0] csrWrData,
  output logic            csrWrOk,
  input  logic            pokeEn,
  input  logic [1:0]      pokeSel,
  input  logic [XLEN-1:0] pokeData,
  input  logic            instEnd,
  output logic [XLEN-1:0] ctrlRd,
  output logic [XLEN-1:0] cmpRd,
  output logic [XLEN-1:0] auxRd,
  output logic [XLEN-1:0] infoRd,
  output logic [3:0]      modFlags,
  output logic [3:0]      trigType,
  output logic            dbgOwned,
  output logic [5:0]      trigAction,
  output logic            trigEnabled,
  output logic            trigChain,
  output logic            trigTiming
);

  dtrig_strobe_t   stb;
  logic [XLEN-1:0] ctrlNow;

  dtrig_ctrl ctrl_i (
    .csrWrEn(csrWrEn), .csrSel(csrSel), .csrDbgMode(csrDbgMode),
    .pokeEn(pokeEn), .pokeSel(pokeSel), .instEnd(instEnd),
    .dbgOwned(dbgOwned), .csrWrOk(csrWrOk), .stb(stb)
  );

  dtrig_regs #(
    .XLEN(XLEN), .RST_CTRL(RST_CTRL), .RST_CMP(RST_CMP), .RST_AUX(RST_AUX), .RST_INFO(RST_INFO),
    .WMASK_CTRL(WMASK_CTRL), .WMASK_CMP(WMASK_CMP), .WMASK_AUX(WMASK_AUX), .WMASK_INFO(WMASK_INFO),
    .PMASK_CTRL(PMASK_CTRL), .PMASK_CMP(PMASK_CMP), .PMASK_AUX(PMASK_AUX), .PMASK_INFO(PMASK_INFO),
    .NAPOT_MASK(NAPOT_MASK)
  ) regs_i (
    .clk(clk), .rstN(rstN), .stb(stb), .csrWrData(csrWrData), .pokeData(pokeData),
    .ctrlNow(ctrlNow), .ctrlRd(ctrlRd), .cmpRd(cmpRd), .auxRd(auxRd), .infoRd(infoRd),
    .modFlags(modFlags)
  );

  dtrig_decode #(.XLEN(XLEN)) decode_i (
    .ctrlNow(ctrlNow), .trigType(trigType), .dbgOwned(dbgOwned), .trigAction(trigAction),
    .trigEnabled(trigEnabled), .trigChain(trigChain), .trigTiming(trigTiming)
  );

endmodule

// File: rtl/dtrig_unit_chk.sv
module dtrig_unit_chk #(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] WMASK_CTRL = '1,
  parameter logic [XLEN-1:0] WMASK_CMP  = '1,
  parameter logic [XLEN-1:0] NAPOT_MASK = 32'hBFFF_FFFF
)(
  input logic            clk,
  input logic            rstN,
  input logic            csrWrEn,
  input logic [1:0]      csrSel,
  input logic            csrDbgMode,
  input logic [XLEN-1:0] csrWrData,
  input logic            csrWrOk,
  input logic            pokeEn,
  input logic            instEnd,
  input logic [XLEN-1:0] cmpRd,
  input logic [3:0]      modFlags,
  input logic [3:0]      trigType,
  input logic            dbgOwned,
  input logic [5:0]      trigAction
);

  // R2: a type-0 control write lands as disabled
  p_type_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrOk && csrSel == 2'd0 && csrWrData[XLEN-1 -: 4] == 4'd0 && WMASK_CTRL[XLEN-1 -: 4] == 4'hF)
    |=> trigType == 4'd15);

  // R3, R6: unowned address/data trigger never holds the enter-debug action
  p_no_unowned_dbg_action_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((trigType == 4'd2 || trigType == 4'd6) && !dbgOwned) |-> trigAction != 6'd1);

  // R4: a refused compare write leaves the compare value stable
  p_refused_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrSel == 2'd1 && dbgOwned && !csrDbgMode && !pokeEn) |=> $stable(cmpRd));

  // R4: refusal only when owned and not in debug mode
  p_refuse_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && !csrWrOk) |-> (dbgOwned && !csrDbgMode));

  // R5: ownership bit cannot move through a non-debug CSR write
  p_own_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrOk && csrSel == 2'd0 && !csrDbgMode && !pokeEn) |=> $stable(dbgOwned));

  // R8: all ones under the newer format becomes the NAPOT mask
  p_napot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrOk && csrSel == 2'd1 && csrWrData == '1 && trigType == 4'd6 && WMASK_CMP == '1)
    |=> cmpRd == NAPOT_MASK);

  // R10: accepted write raises its flag; a bare instruction end clears all
  p_mod_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrOk && csrSel == 2'd1) |=> modFlags[1]);

  p_mod_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (instEnd && !csrWrOk) |=> modFlags == 4'd0);

endmodule

bind dtrig_unit dtrig_unit_chk #(
  .XLEN(XLEN), .WMASK_CTRL(WMASK_CTRL), .WMASK_CMP(WMASK_CMP), .NAPOT_MASK(NAPOT_MASK)
) chk_i (
  .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrSel(csrSel), .csrDbgMode(csrDbgMode),
  .csrWrData(csrWrData), .csrWrOk(csrWrOk), .pokeEn(pokeEn), .instEnd(instEnd),
  .cmpRd(cmpRd), .modFlags(modFlags), .trigType(trigType), .dbgOwned(dbgOwned),
  .trigAction(trigAction)
);

// File: tb/dtrig_unit_tb_top.sv
`timescale 1ns/1ps
module dtrig_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [1:0]  csrSel = 2'd0;
  logic        csrDbgMode = 1'b0;
  logic [31:0] csrWrData = '0;
  logic        csrWrOk;
  logic        pokeEn = 1'b0;
  logic [1:0]  pokeSel = 2'd0;
  logic [31:0] pokeData = '0;
  logic        instEnd = 1'b0;
  logic [31:0] ctrlRd, cmpRd, auxRd, infoRd;
  logic [3:0]  modFlags, trigType;
  logic        dbgOwned, trigEnabled, trigChain, trigTiming;
  logic [5:0]  trigAction;

  int tests = 0;
  int fails = 0;
  logic okSeen;

  always #5 clk = ~clk;

  dtrig_unit dut_i (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrSel(csrSel), .csrDbgMode(csrDbgMode),
    .csrWrData(csrWrData), .csrWrOk(csrWrOk), .pokeEn(pokeEn), .pokeSel(pokeSel),
    .pokeData(pokeData), .instEnd(instEnd), .ctrlRd(ctrlRd), .cmpRd(cmpRd), .auxRd(auxRd),
    .infoRd(infoRd), .modFlags(modFlags), .trigType(trigType), .dbgOwned(dbgOwned),
    .trigAction(trigAction), .trigEnabled(trigEnabled), .trigChain(trigChain),
    .trigTiming(trigTiming)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // One cycle of stimulus; okSeen holds csrWrOk sampled before the edge.
  task automatic drive(input logic we, input logic [1:0] sel, input logic dbg, input logic [31:0] d,
                       input logic pe, input logic [1:0] psel, input logic [31:0] pd, input logic ie);
    @(negedge clk);
    csrWrEn = we; csrSel = sel; csrDbgMode = dbg; csrWrData = d;
    pokeEn = pe; pokeSel = psel; pokeData = pd; instEnd = ie;
    #1 okSeen = csrWrOk;
    @(negedge clk);
    csrWrEn = 1'b0; pokeEn = 1'b0; instEnd = 1'b0; csrDbgMode = 1'b0;
  endtask

  task automatic csrW(input logic [1:0] sel, input logic dbg, input logic [31:0] d);
    drive(1'b1, sel, dbg, d, 1'b0, 2'd0, '0, 1'b0);
  endtask

  task automatic pokeW(input logic [1:0] sel, input logic [31:0] d);
    drive(1'b0, 2'd0, 1'b0, '0, 1'b1, sel, d, 1'b0);
  endtask

  task automatic endInst();
    drive(1'b0, 2'd0, 1'b0, '0, 1'b0, 2'd0, '0, 1'b1);
  endtask

  task automatic t_reset();
    check("R1 ctrl", ctrlRd, 32'hF000_0000);
    check("R1 cmp", cmpRd, 32'h0);
    check("R1 aux", auxRd, 32'h0);
    check("R1 info", infoRd, 32'h0100_007C);
    check("R1 flags", 32'(modFlags), 32'h0);
    check("R1 type", 32'(trigType), 32'd15);
  endtask

  task automatic t_typeLegal();
    csrW(2'd0, 1'b0, 32'h0000_0045);
    check("R2 accepted", 32'(okSeen), 32'd1);
    endInst();
    check("R2 ctrl", ctrlRd, 32'hF000_0045);
    check("R2 enable", 32'(trigEnabled), 32'd0);
  endtask

  task automatic t_actionForce();
    csrW(2'd0, 1'b0, 32'h2000_1040);
    endInst();
    check("R3 addr action cleared, R9 maskmax", ctrlRd, 32'h2020_0040);
    csrW(2'd0, 1'b0, 32'h3000_0205);
    endInst();
    check("R3 icount action cleared", ctrlRd, 32'h3000_0200);
    csrW(2'd0, 1'b1, 32'h2800_1840);
    endInst();
    check("R3 owned keeps action", ctrlRd, 32'h2820_1840);
    check("R3 action field", 32'(trigAction), 32'd1);
  endtask

  task automatic t_ownership();
    csrW(2'd1, 1'b0, 32'h0000_0055);
    check("R4 cmp refused", 32'(okSeen), 32'd0);
    check("R4 no flag", 32'(modFlags), 32'h0);
    csrW(2'd0, 1'b0, 32'h0000_0000);
    check("R4 ctrl refused", 32'(okSeen), 32'd0);
    check("R4 cmp kept", cmpRd, 32'h0);
    check("R4 ctrl kept", ctrlRd, 32'h2820_1840);
    csrW(2'd1, 1'b1, 32'h0000_00AA);
    check("R4 debug write ok", cmpRd, 32'h0000_00AA);
    csrW(2'd0, 1'b1, 32'h2000_0040);
    endInst();
    check("R5 debug clears owner", ctrlRd, 32'h2020_0040);
    csrW(2'd0, 1'b0, 32'h2800_0040);
    endInst();
    check("R5 owner bit protected", ctrlRd, 32'h2020_0040);
    check("R5 owned out", 32'(dbgOwned), 32'd0);
  endtask

  task automatic t_poke();
    pokeW(2'd0, 32'h2000_1040);
    check("R6 poke action cleared", ctrlRd, 32'h2000_0040);
    pokeW(2'd0, 32'h2800_1040);
    check("R6 poke owned keeps", ctrlRd, 32'h2800_1040);
    pokeW(2'd0, 32'h0000_0000);
    check("R6 poke no type legalise", 32'(trigType), 32'd0);
    pokeW(2'd0, 32'h3000_0205);
    check("R6 poke icount", ctrlRd, 32'h3000_0205);
    check("R12 icount action", 32'(trigAction), 32'd5);
    check("R12 icount timing", 32'(trigTiming), 32'd1);
    check("R12 icount enable", 32'(trigEnabled), 32'd1);
  endtask

  task automatic t_masks();
    pokeW(2'd2, 32'hDEAD_BEEF);
    check("R7 aux poke", auxRd, 32'hDEAD_BEEF);
    csrW(2'd2, 1'b0, 32'h1234_5678);
    check("R7 aux csr mask", auxRd, 32'hDEAD_5678);
    csrW(2'd3, 1'b0, 32'hFFFF_FFFF);
    check("R7 info csr masked", infoRd, 32'h0100_007C);
    endInst();
  endtask

  task automatic t_napot();
    csrW(2'd0, 1'b0, 32'h6000_0040);
    csrW(2'd1, 1'b0, 32'hFFFF_FFFF);
    check("R8 napot substituted", cmpRd, 32'hBFFF_FFFF);
    csrW(2'd1, 1'b0, 32'h0000_1234);
    check("R8 plain value", cmpRd, 32'h0000_1234);
    csrW(2'd0, 1'b0, 32'h2000_0040);
    csrW(2'd1, 1'b0, 32'hFFFF_FFFF);
    check("R8 type2 keeps ones", cmpRd, 32'hFFFF_FFFF);
    endInst();
    check("R9 maskmax type2", ctrlRd, 32'h2020_0040);
  endtask

  task automatic t_readPrev();
    csrW(2'd0, 1'b0, 32'hF000_0000);
    check("R10 old value read", ctrlRd, 32'h2020_0040);
    check("R10 ctrl flag", 32'(modFlags), 32'h1);
    csrW(2'd0, 1'b0, 32'hF000_0001);
    check("R10 still first old", ctrlRd, 32'h2020_0040);
    drive(1'b1, 2'd0, 1'b0, 32'hF000_0002, 1'b0, 2'd0, '0, 1'b1);
    check("R10 end+write keeps flag", 32'(modFlags), 32'h1);
    check("R10 end+write prev", ctrlRd, 32'hF000_0001);
    endInst();
    check("R10 live after end", ctrlRd, 32'hF000_0002);
    check("R10 flags cleared", 32'(modFlags), 32'h0);
  endtask

  task automatic t_priority();
    drive(1'b1, 2'd1, 1'b0, 32'h11, 1'b1, 2'd1, 32'h22, 1'b0);
    check("R11 csr wins", cmpRd, 32'h11);
    check("R10 cmp flag bit", 32'(modFlags), 32'h2);
    drive(1'b1, 2'd1, 1'b0, 32'h33, 1'b1, 2'd2, 32'h44, 1'b0);
    check("R11 csr other", cmpRd, 32'h33);
    check("R11 poke other", auxRd, 32'h44);
    endInst();
  endtask

  task automatic t_decode();
    csrW(2'd0, 1'b1, 32'h2004_0008);
    check("R12 timing", 32'(trigTiming), 32'd1);
    check("R12 enable u", 32'(trigEnabled), 32'd1);
    check("R12 chain off", 32'(trigChain), 32'd0);
    csrW(2'd0, 1'b1, 32'h6180_0800);
    check("R12 type6 virt enable", 32'(trigEnabled), 32'd1);
    check("R12 chain on", 32'(trigChain), 32'd1);
    check("R12 type6 timing", 32'(trigTiming), 32'd0);
    csrW(2'd0, 1'b1, 32'h5000_0040);
    check("R12 other type off", 32'(trigEnabled), 32'd0);
    endInst();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_typeLegal();
    t_actionForce();
    t_ownership();
    t_poke();
    t_masks();
    t_napot();
    t_readPrev();
    t_priority();
    t_decode();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule